// File: doc/BRIEF.md
# Packet Timestamp Latch Bank

This block freezes the running 64-bit nanosecond time when a packet event strobe arrives, and keeps that value until software collects it. A receive event lands in one of several receive slots. The number of the slot used is reported next to the capture, so that number can travel with the packet to the receive descriptor. A transmit event lands in a single transmit latch. Software reads each value as two 32-bit words, low word first. The high-word read frees the entry, so the low word can never be overwritten before software has taken it.

Each entry stays occupied until its high word is read. If a timestamped receive packet is lost before software reads its entry, that slot stays full. Once every slot is full, later receive events get no timestamp and a sticky overflow flag records the loss. A single clear read releases every entry and the overflow flag at once, so software can recover from this hung state. A transmit capture raises a level interrupt while the transmit latch holds a value, provided the interrupt enable bit in the control word is set.

Top module: `pkt_ts_latch_bank`

## Requirements
- R1: After a synchronous active-low reset, every slot and the transmit latch are empty, the overflow flag and the interrupt enable are 0, `tx_irq` is 0, `rx_cap_vld` is 0, and a status read returns 0.
- R2: An `rx_evt` pulse stores `cur_time` from that clock edge in the lowest-numbered free receive slot. In the next cycle `rx_cap_vld` is 1 and `rx_cap_idx` holds the slot number.
- R3: An `rx_evt` when all receive slots are occupied and none is being released stores nothing and changes no slot. `rx_cap_vld` stays 0, and the sticky overflow flag (status bit 9) is set until a clear read.
- R4: A read of receive slot i's high word (address 9+2i) frees slot i and clears status bit i. A read of its low word (address 8+2i) changes no state.
- R5: If a high-word release and an `rx_evt` hit on the same edge, the release takes effect first. The freed slot then counts as free when the lowest free slot is chosen.
- R6: A `tx_evt` stores `cur_time` in the transmit latch only when the latch is empty. Status bit 8 then shows it occupied. Later `tx_evt` pulses are ignored until the transmit high word (address 3) is read. The low word is at address 2.
- R7: `tx_irq` is 1 exactly while the transmit latch is occupied and control bit 0 (interrupt enable) is 1.
- R8: A read of address 4 returns the status word as it stood before the read. It frees all receive slots and the transmit latch and clears the overflow flag.
- R9: A read issued with `rd_en` at address A returns its data on `rd_data`, with `rd_valid` high, in the following cycle. The status word at address 1 carries receive occupancy in bits 0..N-1, transmit occupancy in bit 8 and overflow in bit 9. Unmapped addresses read 0.
- R10: A write with `wr_en` to address 0 sets the interrupt enable to `wr_data[0]`. A read of address 0 returns it in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 64 | Running nanosecond time |
| rx_evt | input | 1 | Receive packet timestamp strobe |
| tx_evt | input | 1 | Transmit packet timestamp strobe |
| rx_cap_vld | output | 1 | A receive capture was stored in the previous cycle |
| rx_cap_idx | output | 2 | Slot used by that capture |
| tx_irq | output | 1 | Transmit timestamp ready interrupt (level) |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read word address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Every result of this block is due exactly one clock after the edge that caused it:
- Read data and `rd_valid` follow `rd_en` by one cycle.
- The capture report follows `rx_evt` by one cycle.
- `tx_irq` rises one cycle after the capturing `tx_evt` and falls one cycle after the releasing high-word read.
- Releases and captures on the same edge resolve within that edge.

The bench drives inputs on the falling edge. It advances a behavioural model of slots, flags and pending read data on each rising edge, and compares the ports with that model on the next falling edge. Directed checks sample at that same falling edge, so each comparison falls in the cycle where the output is due.

// File: rtl/pkt_ts_pkg.sv
// Package: shared address map and status bit positions for the
// packet timestamp latch bank. Assumes word addresses, one 32-bit word each.
package pkt_ts_pkg;
    // control word: bit 0 enables the transmit interrupt
    localparam int A_CTRL    = 0;
    // status word: occupancy and overflow flags
    localparam int A_STAT    = 1;
    // transmit latch words
    localparam int A_TX_LO   = 2;
    localparam int A_TX_HI   = 3;
    // clear read: frees everything
    localparam int A_CLR     = 4;
    // receive slot i: low word at base+2i, high word at base+2i+1
    localparam int A_RX_BASE = 8;

    localparam int STAT_TX_BIT  = 8;
    localparam int STAT_OVF_BIT = 9;

    // low-word address of receive slot i
    function automatic int rx_lo_addr(input int i);
        return A_RX_BASE + 2 * i;
    endfunction

    // high-word address of receive slot i
    function automatic int rx_hi_addr(input int i);
        return A_RX_BASE + 2 * i + 1;
    endfunction
endpackage

// File: rtl/pkt_ts_slot.sv
// Module: one timestamp latch entry.
// Holds a time value and an occupied flag. A release frees the entry; a
// load in the same cycle is applied after the release. A load into an
// occupied entry that is not being released is ignored.
module pkt_ts_slot #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            release_i,
    input  logic [TS_W-1:0] din_i,
    output logic            valid_o,
    output logic [TS_W-1:0] value_o
);
    logic taking;

    // accept a load only into an entry that is free after this cycle's release
    always_comb taking = load_i && (!valid_o || release_i);

    // entry state: release first, then capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            value_o <= '0;
        end else if (taking) begin
            valid_o <= 1'b1;
            value_o <= din_i;
        end else if (release_i) begin
            valid_o <= 1'b0;
        end
    end

    // R4: a release with no load leaves the entry free
    a_r4_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        release_i && !load_i |=> !valid_o);

    // R6: an occupied entry that is not released keeps its value
    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !release_i |=> valid_o && $stable(value_o));

    // R2: a load into a free entry stores the presented time
    a_r2_load_stores: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !valid_o |=> valid_o && (value_o == $past(din_i)));
endmodule

// File: rtl/pkt_ts_rx_alloc.sv
// Module: receive slot allocator.
// Picks the lowest-numbered slot that is free once this cycle's releases
// are applied. Purely combinational; clock and reset serve the assertions.
module pkt_ts_rx_alloc #(
    parameter int N_RX  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [N_RX-1:0]  occ_i,
    input  logic [N_RX-1:0]  rel_i,
    output logic [N_RX-1:0]  grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             hit_o,
    output logic             drop_o
);
    logic [N_RX-1:0] free_mask;

    // a slot is free if empty or being released this cycle
    always_comb free_mask = ~occ_i | rel_i;

    // lowest-index priority pick among free slots
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        hit_o   = 1'b0;
        for (int i = 0; i < N_RX; i++) begin
            if (req_i && free_mask[i] && !hit_o) begin
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
                hit_o      = 1'b1;
            end
        end
    end

    // a request with no free slot is lost
    always_comb drop_o = req_i && !hit_o;

    // R2: at most one slot is granted
    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R3: a drop only happens when every slot is held and none is released
    a_r3_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> (&occ_i) && (rel_i == '0));

    // R5: a granted slot is never one that stays occupied
    a_r5_grant_is_free: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((grant_o & occ_i & ~rel_i) == '0));
endmodule

// File: rtl/pkt_ts_regs.sv
// Module: register read/write port for the latch bank.
// Decodes reads into release strobes, muxes read data into a register
// (one cycle read latency) and holds the control word. Assumes N_RX <= 8
// and DATA_W >= 10 so status fields fit.
module pkt_ts_regs
    import pkt_ts_pkg::*;
#(
    parameter int N_RX   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    localparam int TS_W  = 2 * DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [N_RX-1:0][TS_W-1:0]  rx_vals,
    input  logic [N_RX-1:0]            rx_occ,
    input  logic [TS_W-1:0]            tx_val,
    input  logic                       tx_occ,
    input  logic                       ovf,
    output logic                       irq_en,
    output logic [N_RX-1:0]            rx_rel,
    output logic                       tx_rel,
    output logic                       clr_all,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data
);
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] rdata_n;
    logic              wdata_unused;

    // upper control bits are reserved
    always_comb wdata_unused = ^wr_data[DATA_W-1:1];

    // status word assembly
    always_comb begin
        status                 = '0;
        status[N_RX-1:0]       = rx_occ;
        status[STAT_TX_BIT]    = tx_occ;
        status[STAT_OVF_BIT]   = ovf;
    end

    // clear read strobe
    always_comb clr_all = rd_en && (rd_addr == ADDR_W'(A_CLR));

    // transmit release on its high-word read or a clear
    always_comb tx_rel = clr_all || (rd_en && (rd_addr == ADDR_W'(A_TX_HI)));

    // per-slot release on its high-word read or a clear
    for (genvar g = 0; g < N_RX; g++) begin : g_rel
        always_comb rx_rel[g] = clr_all ||
            (rd_en && (rd_addr == ADDR_W'(rx_hi_addr(g))));
    end

    // read data mux over the address map
    always_comb begin
        rdata_n = '0;
        if (rd_addr == ADDR_W'(A_CTRL))  rdata_n[0] = irq_en;
        if (rd_addr == ADDR_W'(A_STAT))  rdata_n = status;
        if (rd_addr == ADDR_W'(A_CLR))   rdata_n = status;
        if (rd_addr == ADDR_W'(A_TX_LO)) rdata_n = tx_val[DATA_W-1:0];
        if (rd_addr == ADDR_W'(A_TX_HI)) rdata_n = tx_val[TS_W-1:DATA_W];
        for (int i = 0; i < N_RX; i++) begin
            if (rd_addr == ADDR_W'(rx_lo_addr(i))) rdata_n = rx_vals[i][DATA_W-1:0];
            if (rd_addr == ADDR_W'(rx_hi_addr(i))) rdata_n = rx_vals[i][TS_W-1:DATA_W];
        end
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rdata_n;
        end
    end

    // control word write
    always_ff @(posedge clk) begin
        if (!rst_n)                                     irq_en <= 1'b0;
        else if (wr_en && wr_addr == ADDR_W'(A_CTRL))   irq_en <= wr_data[0];
    end

    // R9: a read is answered exactly one cycle later
    a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R10: a control write lands in the enable bit
    a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == ADDR_W'(A_CTRL)) |=> irq_en == $past(wr_data[0]));
endmodule

// File: rtl/pkt_ts_latch_bank.sv
// Module: packet timestamp latch bank (top).
// Captures cur_time into the lowest free receive slot on rx_evt, and into
// the transmit latch on tx_evt when it is empty. Entries are freed by
// high-word reads or a clear read. Assumes event strobes are single-cycle
// and synchronous to clk.
module pkt_ts_latch_bank
    import pkt_ts_pkg::*;
#(
    parameter int  N_RX   = 4,
    parameter int  DATA_W = 32,
    parameter int  ADDR_W = 5,
    localparam int TS_W   = 2 * DATA_W,
    localparam int IDX_W  = $clog2(N_RX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   cur_time,
    input  logic              rx_evt,
    input  logic              tx_evt,
    output logic              rx_cap_vld,
    output logic [IDX_W-1:0]  rx_cap_idx,
    output logic              tx_irq,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [N_RX-1:0]            rx_occ;
    logic [N_RX-1:0][TS_W-1:0]  rx_vals;
    logic [N_RX-1:0]            rx_rel;
    logic [N_RX-1:0]            grant;
    logic [IDX_W-1:0]           grant_idx;
    logic                       hit;
    logic                       drop;
    logic                       tx_occ;
    logic [TS_W-1:0]            tx_val;
    logic                       tx_rel;
    logic                       clr_all;
    logic                       irq_en;
    logic                       ovf;

    // receive slot allocation
    pkt_ts_rx_alloc #(.N_RX(N_RX), .IDX_W(IDX_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .req_i(rx_evt), .occ_i(rx_occ),
        .rel_i(rx_rel), .grant_o(grant), .idx_o(grant_idx),
        .hit_o(hit), .drop_o(drop)
    );

    // receive slots
    for (genvar g = 0; g < N_RX; g++) begin : g_rx
        pkt_ts_slot #(.TS_W(TS_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .load_i(grant[g]),
            .release_i(rx_rel[g]), .din_i(cur_time),
            .valid_o(rx_occ[g]), .value_o(rx_vals[g])
        );
    end

    // transmit latch
    pkt_ts_slot #(.TS_W(TS_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load_i(tx_evt), .release_i(tx_rel),
        .din_i(cur_time), .valid_o(tx_occ), .value_o(tx_val)
    );

    // register port
    pkt_ts_regs #(.N_RX(N_RX), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rx_vals(rx_vals), .rx_occ(rx_occ), .tx_val(tx_val),
        .tx_occ(tx_occ), .ovf(ovf), .irq_en(irq_en), .rx_rel(rx_rel),
        .tx_rel(tx_rel), .clr_all(clr_all), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    // sticky overflow: set by a lost capture, cleared by a clear read
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (clr_all) ovf <= 1'b0;
        else if (drop)    ovf <= 1'b1;
    end

    // capture report one cycle after the event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cap_vld <= 1'b0;
            rx_cap_idx <= '0;
        end else begin
            rx_cap_vld <= hit;
            if (hit) rx_cap_idx <= grant_idx;
        end
    end

    // transmit interrupt level
    always_comb tx_irq = tx_occ && irq_en;

    // R3: once set, overflow holds until a clear read
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr_all |=> ovf);

    // R3: a full bank with no release reports no capture
    a_r3_full_no_report: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt && (&rx_occ) && (rx_rel == '0) |=> !rx_cap_vld);

    // R8: a clear read with no new event empties everything
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all && !rx_evt && !tx_evt |=> (rx_occ == '0) && !tx_occ && !ovf);

    // R7: releasing the transmit latch drops the interrupt
    a_r7_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rel && !tx_evt |=> !tx_irq);
endmodule

// File: tb/pkt_ts_latch_bank_tb.sv
`timescale 1ns/100ps
module pkt_ts_latch_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cur_time = 64'h0000_0123_4567_8000;
    logic        rx_evt = 1'b0, tx_evt = 1'b0;
    logic        rx_cap_vld, tx_irq, rd_valid;
    logic [1:0]  rx_cap_idx;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;

    int n_chk = 0, n_err = 0;

    pkt_ts_latch_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .rx_evt(rx_evt),
        .tx_evt(tx_evt), .rx_cap_vld(rx_cap_vld), .rx_cap_idx(rx_cap_idx),
        .tx_irq(tx_irq), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    initial forever begin
        @(negedge clk);
        cur_time = cur_time + 64'd8;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    longint unsigned m_slot[4];
    bit [3:0]        m_occ;
    longint unsigned m_tx;
    bit              m_txo, m_ovf, m_en, m_rdv, m_capv, live;
    int              m_capi;
    logic [31:0]     m_rdd;

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] st;
        st = {22'd0, m_ovf, m_txo, 4'd0, m_occ};
        if (a == 0) return {31'd0, m_en};
        if (a == 1 || a == 4) return st;
        if (a == 2) return m_tx[31:0];
        if (a == 3) return m_tx[63:32];
        for (int i = 0; i < 4; i++) begin
            if (a == 8 + 2 * i) return m_slot[i][31:0];
            if (a == 9 + 2 * i) return m_slot[i][63:32];
        end
        return 32'd0;
    endfunction

    always @(posedge clk) begin : model
        bit [3:0] rel;
        bit       trel, clr;
        int       w;
        if (!rst_n) begin
            m_occ = '0; m_txo = 0; m_ovf = 0; m_en = 0; m_rdv = 0;
            m_capv = 0; m_capi = 0; m_rdd = '0; m_tx = 0; live = 1;
            for (int i = 0; i < 4; i++) m_slot[i] = 0;
        end else begin
            clr  = rd_en && rd_addr == 5'd4;
            rel  = clr ? 4'hF : 4'h0;
            trel = clr || (rd_en && rd_addr == 5'd3);
            for (int i = 0; i < 4; i++)
                if (rd_en && rd_addr == 5'(9 + 2 * i)) rel[i] = 1'b1;
            m_rdv = rd_en;
            if (rd_en) m_rdd = m_read(int'(rd_addr));
            if (wr_en && wr_addr == 5'd0) m_en = wr_data[0];
            m_occ = m_occ & ~rel;
            if (trel) m_txo = 0;
            if (clr) m_ovf = 0;
            m_capv = 0;
            if (rx_evt) begin
                w = -1;
                for (int i = 0; i < 4; i++) if (w < 0 && !m_occ[i]) w = i;
                if (w < 0) m_ovf = 1;
                else begin
                    m_slot[w] = cur_time; m_occ[w] = 1'b1;
                    m_capv = 1; m_capi = w;
                end
            end
            if (tx_evt && !m_txo) begin m_tx = cur_time; m_txo = 1; end
        end
    end

    // compare ports with the model every cycle, away from the rising edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk("R9 rd_valid", 64'(rd_valid), 64'(m_rdv));
            if (m_rdv) chk("R9 rd_data", 64'(rd_data), 64'(m_rdd));
            chk("R2 rx_cap_vld", 64'(rx_cap_vld), 64'(m_capv));
            if (m_capv) chk("R2 rx_cap_idx", 64'(rx_cap_idx), 64'(m_capi));
            chk("R7 tx_irq", 64'(tx_irq), 64'(m_txo && m_en));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_read(input int a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = 5'(a);
        @(negedge clk); d = rd_data; rd_en = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rx_pulse(output logic [63:0] t, output logic v, output logic [1:0] idx);
        @(negedge clk); rx_evt = 1'b1; #1 t = cur_time;
        @(negedge clk); rx_evt = 1'b0; v = rx_cap_vld; idx = rx_cap_idx;
    endtask

    task automatic tx_pulse(output logic [63:0] t);
        @(negedge clk); tx_evt = 1'b1; #1 t = cur_time;
        @(negedge clk); tx_evt = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [63:0] t[4];
        logic [63:0] tn, ttx, tdummy;
        logic        v;
        logic [1:0]  idx;
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 tx_irq", 64'(tx_irq), 64'd0);
        chk("R1 rx_cap_vld", 64'(rx_cap_vld), 64'd0);
        do_read(1, d); chk("R1 status", 64'(d), 64'h0);

        // R10: control write and read back
        do_write(0, 32'h1);
        do_read(0, d); chk("R10 ctrl", 64'(d), 64'h1);

        // R2: fill all four slots in order
        for (int i = 0; i < 4; i++) begin
            rx_pulse(t[i], v, idx);
            chk("R2 fill vld", 64'(v), 64'd1);
            chk("R2 fill idx", 64'(idx), 64'(i));
        end

        // R3: fifth capture dropped, overflow set
        rx_pulse(tn, v, idx);
        chk("R3 drop vld", 64'(v), 64'd0);
        do_read(1, d); chk("R3 status full+ovf", 64'(d), 64'h20F);

        // R4: low word read keeps slot; high word read frees it
        do_read(12, d); chk("R4 slot2 lo", 64'(d), 64'(t[2][31:0]));
        do_read(1, d);  chk("R4 status after lo", 64'(d), 64'h20F);
        do_read(13, d); chk("R4 slot2 hi", 64'(d), 64'(t[2][63:32]));
        do_read(1, d);  chk("R4 status after hi", 64'(d), 64'h20B);

        // R3 and R4: the freed slot is reused
        rx_pulse(t[2], v, idx);
        chk("R4 reuse vld", 64'(v), 64'd1);
        chk("R4 reuse idx", 64'(idx), 64'd2);
        do_read(12, d); chk("R4 reuse value", 64'(d), 64'(t[2][31:0]));

        // R5: release slot 1 and capture on the same edge
        @(negedge clk); rd_en = 1'b1; rd_addr = 5'd11; rx_evt = 1'b1; #1 tn = cur_time;
        @(negedge clk);
        chk("R5 same-edge vld", 64'(rx_cap_vld), 64'd1);
        chk("R5 same-edge idx", 64'(rx_cap_idx), 64'd1);
        chk("R5 old hi word", 64'(rd_data), 64'(t[1][63:32]));
        rd_en = 1'b0; rx_evt = 1'b0;
        do_read(10, d); chk("R5 new lo word", 64'(d), 64'(tn[31:0]));

        // R6 and R7: transmit capture, hold, interrupt
        tx_pulse(ttx);
        chk("R7 irq raised", 64'(tx_irq), 64'd1);
        tx_pulse(tdummy);
        do_read(2, d); chk("R6 tx lo held", 64'(d), 64'(ttx[31:0]));
        do_read(1, d); chk("R6 status tx bit", 64'(d), 64'h30F);
        do_read(3, d); chk("R6 tx hi", 64'(d), 64'(ttx[63:32]));
        chk("R7 irq cleared", 64'(tx_irq), 64'd0);

        // R7: interrupt masked by the enable bit
        do_write(0, 32'h0);
        tx_pulse(ttx);
        chk("R7 irq masked", 64'(tx_irq), 64'd0);
        do_read(2, d); chk("R6 tx recaptured", 64'(d), 64'(ttx[31:0]));

        // R8: clear read returns old status and frees all
        do_read(4, d); chk("R8 clear returns status", 64'(d), 64'h30F);
        do_read(1, d); chk("R8 status after clear", 64'(d), 64'h0);

        // R9: unmapped address reads zero
        do_read(5, d); chk("R9 unmapped", 64'(d), 64'h0);

        // R2: capture after clear starts at slot 0
        rx_pulse(tn, v, idx);
        chk("R2 post-clear idx", 64'(idx), 64'd0);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule